// File: doc/BRIEF.md
# Two-Level Message Interrupt Status Unit

This unit gathers message-signalled interrupts that arrive at a root-port style controller and presents them to a processor through two status registers. It also drives one level-sensitive interrupt line.

- **Local register.** It holds independent interrupt sources. Bit 28 of this register is a summary flag that every incoming message sets.
- **Message register.** It has one bit per message number, 0 to 31, and shows which messages have arrived.
- **Clearing.** Both registers are write-one-to-clear. A source event that lands in the same cycle as a clear of the same bit always wins.

Because of this, a message that arrives between the processor's read and its clear is never dropped. Handler software can therefore clear the summary flag first, then read and service the per-message bits, with no race.

Messages enter as a one-cycle strobe with a 5-bit message number. The strobe is always accepted, so this input has no back-pressure and no ready signal. Other local sources enter as per-bit pulses.

The register port is a single-cycle request interface: valid, write, address and write data. A read answers with a response strobe and data exactly one cycle after the request. The register port never stalls.

Top module: `msi_irq_status`

## Requirements
- R1: After reset both status registers read zero, `irq` is low and `rsp_valid` is low.
- R2: A cycle with `msg_valid` high and `msg_num` = n sets bit n of the message register (address 0x4), visible from the next cycle.
- R3: Every cycle with `msg_valid` high sets bit 28 of the local register (address 0x0), whatever the state of the message register.
- R4: A high `src_pulse[i]` sets local bit i for each implemented source bit (default bits 7..0), and several sources may set in the same cycle.
- R5: A write sets to zero every register bit written with one and keeps every bit written with zero.
- R6: When a bit is set by a source or a message in the same cycle that a write-one clears it, the bit ends up set.
- R7: `irq` is high in exactly the cycles where at least one local bit is set, starting the cycle after the bit sets.
- R8: A read request returns `rsp_valid` high together with the register's value on the next cycle. Addresses other than 0x0 and 0x4 read as zero.
- R9: Local bits with no attached source (neither an implemented source bit nor bit 28) read zero and ignore source pulses and writes.
- R10: Clearing local bit 28 leaves the message register unchanged, and clearing message bits leaves bit 28 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | Message received strobe, always accepted |
| msg_num | input | 5 | Message number of the received message |
| src_pulse | input | 32 | Local source activation pulses, one per local bit |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address: 0x0 local, 0x4 message |
| bus_wdata | input | 32 | Write data, ones clear bits |
| rsp_valid | output | 1 | Read response strobe, one cycle after a read request |
| rsp_rdata | output | 32 | Read response data |
| irq | output | 1 | Level interrupt toward the processor |

## Verification
The bench builds the block with its default parameters: 32 message numbers and local sources on bits 7..0, plus the bit-28 summary. These defaults put both edges of the message-number range in reach, along with a fully populated message register. They also leave unimplemented local bits on either side of the summary flag, which the bench uses to check that those bits stay zero. With the local sources sitting in the low byte, a pulse on every source line, including the lines with no register bit behind them, can be told apart from the summary flag.

// File: rtl/msi_stat_pkg.sv
package msi_stat_pkg;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned ADDR_W    = 4;
  localparam int unsigned SUM_BIT   = 28;
  localparam logic [ADDR_W-1:0] ADDR_LOCAL = 4'h0;
  localparam logic [ADDR_W-1:0] ADDR_MSG   = 4'h4;
endpackage

// File: rtl/w1c_status_bank.sv
module w1c_status_bank #(
  parameter int unsigned WIDTH = 32,
  parameter logic [WIDTH-1:0] IMPL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set_vec,
  input  logic [WIDTH-1:0] clr_vec,
  output logic [WIDTH-1:0] q
);
  // One flop per implemented bit; set has priority over clear.
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (IMPL[i]) begin : g_flop
      always_ff @(posedge clk) begin
        if (!rst_n)          q[i] <= 1'b0;
        else if (set_vec[i]) q[i] <= 1'b1;
        else if (clr_vec[i]) q[i] <= 1'b0;
      end
    end else begin : g_tie
      assign q[i] = 1'b0;
    end
  end
endmodule

// File: rtl/msg_decode.sv
module msg_decode #(
  parameter int unsigned NUM_MSG = 32,
  parameter int unsigned MSG_W   = 5,
  parameter int unsigned WIDTH   = 32
) (
  input  logic             msg_valid,
  input  logic [MSG_W-1:0] msg_num,
  output logic [WIDTH-1:0] hit
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_hit
    if (i < NUM_MSG) begin : g_live
      assign hit[i] = msg_valid && (msg_num == MSG_W'(i));
    end else begin : g_dead
      assign hit[i] = 1'b0;
    end
  end
endmodule

// File: rtl/reg_port.sv
module reg_port
  import msi_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] local_q,
  input  logic [DATA_W-1:0] msg_q,
  output logic [DATA_W-1:0] clr_local,
  output logic [DATA_W-1:0] clr_msg,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  logic wr_en, rd_en;
  logic [DATA_W-1:0] rd_mux;

  assign wr_en     = bus_valid && bus_write;
  assign rd_en     = bus_valid && !bus_write;
  assign clr_local = (wr_en && bus_addr == ADDR_LOCAL) ? bus_wdata : '0;
  assign clr_msg   = (wr_en && bus_addr == ADDR_MSG)   ? bus_wdata : '0;

  always_comb begin
    unique case (bus_addr)
      ADDR_LOCAL: rd_mux = local_q;
      ADDR_MSG:   rd_mux = msg_q;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_en;
      rsp_rdata <= rd_en ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/msi_irq_status.sv
module msi_irq_status
  import msi_stat_pkg::*;
#(
  parameter int unsigned NUM_MSG = 32,
  parameter int unsigned MSG_W   = (NUM_MSG > 1) ? $clog2(NUM_MSG) : 1,
  parameter logic [DATA_W-1:0] SRC_MASK = 32'h0000_00FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msg_valid,
  input  logic [MSG_W-1:0]  msg_num,
  input  logic [DATA_W-1:0] src_pulse,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              irq
);
  localparam logic [DATA_W-1:0] SUM_MASK   = DATA_W'(1) << SUM_BIT;
  localparam logic [DATA_W-1:0] LOCAL_IMPL = (SRC_MASK & ~SUM_MASK) | SUM_MASK;
  localparam logic [DATA_W-1:0] MSG_IMPL   =
    (NUM_MSG >= DATA_W) ? '1 : DATA_W'((64'd1 << NUM_MSG) - 64'd1);

  logic [DATA_W-1:0] local_q, msg_q;
  logic [DATA_W-1:0] clr_local, clr_msg;
  logic [DATA_W-1:0] msg_hit, local_set;

  msg_decode #(.NUM_MSG(NUM_MSG), .MSG_W(MSG_W), .WIDTH(DATA_W)) u_dec (
    .msg_valid(msg_valid), .msg_num(msg_num), .hit(msg_hit)
  );

  // Summary flag comes straight from the strobe, not from the message register.
  assign local_set = (src_pulse & LOCAL_IMPL & ~SUM_MASK) | (msg_valid ? SUM_MASK : '0);

  w1c_status_bank #(.WIDTH(DATA_W), .IMPL(LOCAL_IMPL)) u_local (
    .clk(clk), .rst_n(rst_n), .set_vec(local_set), .clr_vec(clr_local), .q(local_q)
  );

  w1c_status_bank #(.WIDTH(DATA_W), .IMPL(MSG_IMPL)) u_msg (
    .clk(clk), .rst_n(rst_n), .set_vec(msg_hit), .clr_vec(clr_msg), .q(msg_q)
  );

  reg_port u_port (
    .clk(clk), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .local_q(local_q), .msg_q(msg_q),
    .clr_local(clr_local), .clr_msg(clr_msg),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  assign irq = |local_q;
endmodule

// File: rtl/msi_irq_status_chk.sv
module msi_irq_status_chk
  import msi_stat_pkg::*;
#(
  parameter int unsigned MSG_W = 5,
  parameter logic [DATA_W-1:0] SRC_MASK = 32'h0000_00FF
) (
  input logic              clk,
  input logic              rst_n,
  input logic              msg_valid,
  input logic [MSG_W-1:0]  msg_num,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] local_q,
  input logic [DATA_W-1:0] msg_q,
  input logic              rsp_valid,
  input logic              irq
);
  localparam logic [DATA_W-1:0] IMPL = SRC_MASK | (DATA_W'(1) << SUM_BIT);

  a_r2_msg_sets_bit: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |=> msg_q[$past(msg_num)]);

  a_r3_msg_sets_summary: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |=> local_q[SUM_BIT]);

  a_r5_msg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && bus_write && bus_addr == ADDR_MSG) |=> ((msg_q & $past(msg_q)) == $past(msg_q)));

  a_r7_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
    (local_q != '0) |-> irq);

  a_r8_rsp_timing: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write) |=> rsp_valid);

  a_r9_unimpl_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (local_q & ~IMPL) == '0);
endmodule

bind msi_irq_status msi_irq_status_chk #(.MSG_W(MSG_W), .SRC_MASK(SRC_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_num(msg_num),
  .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
  .local_q(local_q), .msg_q(msg_q), .rsp_valid(rsp_valid), .irq(irq)
);

// File: tb/sim_msi_irq_status.sv
`timescale 1ns/1ps
module sim_msi_irq_status;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        msg_valid = 1'b0;
  logic [4:0]  msg_num = '0;
  logic [31:0] src_pulse = '0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  localparam logic [31:0] SUM = 32'h1000_0000;

  always #2.5 clk = ~clk;

  msi_irq_status u0 (
    .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_num(msg_num),
    .src_pulse(src_pulse), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d, output logic v);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    @(negedge clk);
    bus_valid = 0;
    d = rsp_rdata; v = rsp_valid;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic send(input logic [4:0] n);
    @(negedge clk);
    msg_valid = 1; msg_num = n;
    @(negedge clk);
    msg_valid = 0;
  endtask

  task automatic clear_all();
    wr(4'h0, 32'hFFFF_FFFF);
    wr(4'h4, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    logic [31:0] d; logic v;
    check("R1 irq", {31'b0, irq}, 32'd0);
    check("R1 rsp_valid", {31'b0, rsp_valid}, 32'd0);
    rd(4'h0, d, v); check("R1 local", d, 32'd0);
    rd(4'h4, d, v); check("R1 msg", d, 32'd0);
  endtask

  task automatic t_single_msg();
    logic [31:0] d; logic v;
    send(5'd0);
    rd(4'h4, d, v); check("R8 rsp_valid", {31'b0, v}, 32'd1);
    check("R2 msg0", d, 32'h0000_0001);
    rd(4'h0, d, v); check("R3 summary", d, SUM);
    send(5'd31);
    rd(4'h4, d, v); check("R2 msg31", d, 32'h8000_0001);
    clear_all();
  endtask

  task automatic t_all_msgs();
    logic [31:0] d; logic v;
    for (int i = 0; i < 32; i++) send(5'(i));
    rd(4'h4, d, v); check("R2 all", d, 32'hFFFF_FFFF);
    // summary sets again even though message bit is already set
    wr(4'h0, SUM);
    rd(4'h0, d, v); check("R10 sum cleared", d, 32'd0);
    rd(4'h4, d, v); check("R10 msg kept", d, 32'hFFFF_FFFF);
    send(5'd5);
    rd(4'h0, d, v); check("R3 resummary", d, SUM);
    wr(4'h4, 32'h0000_FFFF);
    rd(4'h4, d, v); check("R5 partial", d, 32'hFFFF_0000);
    rd(4'h0, d, v); check("R10 sum kept", d, SUM);
    clear_all();
  endtask

  task automatic t_local();
    logic [31:0] d; logic v;
    @(negedge clk); src_pulse = 32'h0000_00A5;
    @(negedge clk); src_pulse = 0;
    check("R7 irq high", {31'b0, irq}, 32'd1);
    rd(4'h0, d, v); check("R4 multi", d, 32'h0000_00A5);
    wr(4'h0, 32'h0000_0005);
    rd(4'h0, d, v); check("R5 local w1c", d, 32'h0000_00A0);
    wr(4'h0, 32'h0000_00A0);
    check("R7 irq low", {31'b0, irq}, 32'd0);
  endtask

  task automatic t_unimpl();
    logic [31:0] d; logic v;
    @(negedge clk); src_pulse = ~32'h0000_00FF;
    @(negedge clk); src_pulse = 0;
    rd(4'h0, d, v); check("R9 unimpl src", d, 32'd0);
    check("R9 irq", {31'b0, irq}, 32'd0);
    rd(4'h8, d, v); check("R8 unmapped", d, 32'd0);
    check("R8 unmapped valid", {31'b0, v}, 32'd1);
  endtask

  task automatic t_race();
    logic [31:0] d; logic v;
    send(5'd3); send(5'd9);
    @(negedge clk);
    msg_valid = 1; msg_num = 5'd3;
    bus_valid = 1; bus_write = 1; bus_addr = 4'h4; bus_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    msg_valid = 0; bus_valid = 0; bus_write = 0;
    rd(4'h4, d, v); check("R6 msg race", d, 32'h0000_0008);
    @(negedge clk);
    msg_valid = 1; msg_num = 5'd1; src_pulse = 32'h0000_0002;
    bus_valid = 1; bus_write = 1; bus_addr = 4'h0; bus_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    msg_valid = 0; src_pulse = 0; bus_valid = 0; bus_write = 0;
    rd(4'h0, d, v); check("R6 local race", d, SUM | 32'h2);
    clear_all();
    check("R7 irq after clear", {31'b0, irq}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_single_msg();
    t_all_msgs();
    t_local();
    t_unimpl();
    t_race();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule